// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes charge of an SDRAM command bus after a synchronous reset and walks the memory through its mandatory start-up routine. It first idles the bus with NOP commands for a programmable power-up delay. It then closes every bank with one precharge-all command and issues a fixed number of auto-refresh commands (two by default). Last, it writes the mode register from a configuration word. Every command is followed by a parameterised number of NOP cycles before the next one is allowed.

Before the mode word goes onto the address bus, it is cleaned. The reserved and operating-mode bits are cleared. A CAS-latency field other than 2 or 3 is replaced by latency 3. The burst-length, burst-type and write-burst fields pass through unchanged.

A downstream controller watches two outputs. `cmd_valid` marks the cycles in which a real command, as opposed to a NOP or inhibit, is on the bus. `init_ready` rises once the sequence is complete and stays high until the next reset. All wait times are given in clock cycles, so the integrator converts microseconds and nanoseconds at the system clock rate.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is sampled low, the bus shows INHIBIT. INHIBIT means {cs_n,ras_n,cas_n,we_n} = 1111, with address and bank at 0 and `cmd_valid` and `init_ready` at 0.
- R2: Counting the first rising edge with `rst_n` high as cycle 1, cycles 1 to T_PWR drive NOP, encoded {cs_n,ras_n,cas_n,we_n} = 0111.
- R3: Cycle T_PWR+1 drives PRECHARGE (0010) with address bit 10 set, all other address bits 0 and bank 0.
- R4: After the precharge, T_RP NOP cycles follow, then one AUTO REFRESH (0001) with address and bank 0.
- R5: After each refresh, T_RFC NOP cycles follow. Exactly two refreshes are issued before the mode load.
- R6: After the last refresh wait, one LOAD MODE (0000) is driven with bank 0. Address bits 11..0 carry the cleaned mode word, and any address bits above 11 are 0.
- R7: In the loaded word, bits 11, 10, 8 and 7 are 0. Bits 9 and 3..0 equal the same bits of `mode_cfg`.
- R8: Address bits 6..4 of the loaded word equal `mode_cfg[6:4]` when that field is 010 or 011, and 011 otherwise.
- R9: After the mode load, T_MRD NOP cycles follow. In the next cycle `init_ready` rises and stays high, with NOP on the bus, until reset.
- R10: `cmd_valid` is 1 exactly in the precharge, refresh and mode-load cycles.
- R11: A reset asserted in the middle of the sequence returns the bus to INHIBIT. After release, the whole sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg | input | 12 | Requested mode register word, held stable during the sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Command address bus |
| sd_ba | output | BA_W | Bank address |
| cmd_valid | output | 1 | High in cycles that carry a real command |
| init_ready | output | 1 | Initialization finished; sticky until reset |

## Verification
The assertions take for granted that every wait parameter is at least 1, so two real commands are never adjacent. They also assume `rst_n` changes away from the clock edge. They do not rely on `mode_cfg` being legal, because the cleaning step is what they check. The stimulus drives reset and `mode_cfg` only on falling clock edges and keeps `mode_cfg` fixed through each run. It deliberately supplies words with reserved bits set and with illegal latency codes, so the cleaning paths are exercised without stepping outside the stated assumptions.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encodings and sequencer states for the SDRAM
// start-up sequencer. Assumes commands are packed as {cs_n,ras_n,cas_n,we_n}.
package sdram_init_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_PWR_WAIT,
        ST_PRE,
        ST_PRE_WAIT,
        ST_REF,
        ST_REF_WAIT,
        ST_LMR,
        ST_LMR_WAIT,
        ST_DONE
    } init_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
// Module: down-counter used for every post-command wait.
// Assumes: load has priority; the count sticks at zero until reloaded.
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load a new wait length or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_modeword.sv
// Module: cleans the requested mode word before it is loaded.
// Assumes: 12-bit word; the latency field occupies bits 6..4.
// Bits 11, 10, 8 and 7 are cleared. A latency code other than 2 or 3
// becomes 3. All remaining bits pass through.
module sdram_init_modeword
    import sdram_init_pkg::*;
#(
    parameter logic [2:0] CL_FALLBACK = 3'b011
) (
    input  logic [MODE_W-1:0] raw_word,
    output logic [MODE_W-1:0] clean_word
);

    localparam logic [MODE_W-1:0] KEEP_MASK = 12'b0010_0000_1111;

    logic [2:0] cl_raw;
    logic       cl_legal;

    // Purpose: accept only the two supported latency codes.
    always_comb begin
        cl_raw   = raw_word[6:4];
        cl_legal = (cl_raw == 3'b010) || (cl_raw == 3'b011);
    end

    // Purpose: assemble the cleaned word from kept bits and the latency.
    always_comb begin
        clean_word      = raw_word & KEEP_MASK;
        clean_word[6:4] = cl_legal ? cl_raw : CL_FALLBACK;
    end

endmodule

// File: rtl/sdram_init_ctrl.sv
// Module: ordering state machine of the start-up sequence.
// Assumes: each wait parameter is at least 1; the timer reports zero in the
// last cycle of a wait, so a wait state lasts exactly its parameter.
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int T_PWR = 13300,
    parameter int T_RP  = 3,
    parameter int T_RFC = 9,
    parameter int T_MRD = 2,
    parameter int N_REF = 2,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_zero,
    output init_state_e      state,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val
);

    localparam int REF_W = $clog2(N_REF + 1);

    init_state_e      state_q, state_d;
    logic [REF_W-1:0] ref_done_q;

    // Purpose: choose the next step and the wait to arm on entry to it.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        case (state_q)
            ST_HOLD: begin
                state_d    = ST_PWR_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(T_PWR - 1);
            end
            ST_PWR_WAIT: if (timer_zero) state_d = ST_PRE;
            ST_PRE: begin
                state_d    = ST_PRE_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(T_RP - 1);
            end
            ST_PRE_WAIT: if (timer_zero) state_d = ST_REF;
            ST_REF: begin
                state_d    = ST_REF_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(T_RFC - 1);
            end
            ST_REF_WAIT: begin
                if (timer_zero) begin
                    state_d = (ref_done_q == REF_W'(N_REF)) ? ST_LMR : ST_REF;
                end
            end
            ST_LMR: begin
                state_d    = ST_LMR_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(T_MRD - 1);
            end
            ST_LMR_WAIT: if (timer_zero) state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_HOLD;
        endcase
    end

    // Purpose: register the state and count the refreshes issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_HOLD;
            ref_done_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REF) begin
                ref_done_q <= ref_done_q + 1'b1;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/sdram_init_cmdgen.sv
// Module: decodes the sequencer state into bus pins and handshake outputs.
// Assumes: ADDR_W >= 12 so that bit 10 and the whole mode word fit.
module sdram_init_cmdgen
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  init_state_e       state,
    input  logic [MODE_W-1:0] mode_word,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              valid,
    output logic              ready
);

    localparam int AP_BIT = 10;

    // Purpose: pick the command code, address and flags for this state.
    always_comb begin
        cmd   = CMD_NOP;
        addr  = '0;
        ba    = '0;
        valid = 1'b0;
        ready = 1'b0;
        case (state)
            ST_HOLD: cmd = CMD_INH;
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
                valid        = 1'b1;
            end
            ST_REF: begin
                cmd   = CMD_REF;
                valid = 1'b1;
            end
            ST_LMR: begin
                cmd   = CMD_LMR;
                addr  = ADDR_W'(mode_word);
                valid = 1'b1;
            end
            ST_DONE: ready = 1'b1;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the SDRAM start-up sequencer.
// Drives NOPs for the power-up delay, precharges all banks, refreshes
// N_REF times and loads a cleaned mode word, then raises init_ready.
// Assumes: synchronous active-low reset; all wait parameters >= 1;
// mode_cfg stable while the sequence runs.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int T_PWR  = 13300,
    parameter int T_RP   = 3,
    parameter int T_RFC  = 9,
    parameter int T_MRD  = 2,
    parameter int N_REF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       mode_cfg,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              cmd_valid,
    output logic              init_ready
);

    localparam int MAX_A    = (T_PWR > T_RP) ? T_PWR : T_RP;
    localparam int MAX_B    = (T_RFC > T_MRD) ? T_RFC : T_MRD;
    localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    init_state_e       state;
    logic              timer_load;
    logic              timer_zero;
    logic [CNT_W-1:0]  timer_val;
    logic [MODE_W-1:0] clean_word;
    logic [3:0]        cmd;

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .zero     (timer_zero)
    );

    sdram_init_ctrl #(
        .T_PWR (T_PWR),
        .T_RP  (T_RP),
        .T_RFC (T_RFC),
        .T_MRD (T_MRD),
        .N_REF (N_REF),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_zero (timer_zero),
        .state      (state),
        .timer_load (timer_load),
        .timer_val  (timer_val)
    );

    sdram_init_modeword u_mode (
        .raw_word   (mode_cfg),
        .clean_word (clean_word)
    );

    sdram_init_cmdgen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd (
        .state     (state),
        .mode_word (clean_word),
        .cmd       (cmd),
        .addr      (sd_addr),
        .ba        (sd_ba),
        .valid     (cmd_valid),
        .ready     (init_ready)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_init_seq_checker.sv
// Module: property checker bound to sdram_init_seq.
// Assumes: wait parameters >= 1; reset changes away from clock edges.
module sdram_init_seq_checker #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic              cmd_valid,
    input logic              init_ready
);

    logic [3:0] c;
    logic       was_reset_q;

    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Purpose: remember whether the previous edge sampled reset low.
    always_ff @(posedge clk) begin
        was_reset_q <= !rst_n;
    end

    // R1: after an edge with reset low, the bus is inhibited and not ready.
    always @(negedge clk) begin
        if (was_reset_q === 1'b1) begin
            a_r1_reset_inhibit: assert (c == 4'b1111 && !init_ready && !cmd_valid);
        end
    end

    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> (sd_addr[10] && sd_ba == '0));

    a_r7_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00));

    a_r8_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011));

    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |=> init_ready);

    a_r9_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> (c == 4'b0111 && !cmd_valid));

    a_r10_valid_selects: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!sd_cs_n && c != 4'b0111));

    a_r4_commands_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

bind sdram_init_seq sdram_init_seq_checker #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_ba      (sd_ba),
    .cmd_valid  (cmd_valid),
    .init_ready (init_ready)
);

// File: tb/sdram_init_seq_bench.sv
// Directed bench for sdram_init_seq: one task per scenario, each checking
// the bus cycle by cycle against a schedule derived from the requirements.
module sdram_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int P      = 20;
    localparam int RP     = 3;
    localparam int RFC    = 5;
    localparam int MRD    = 2;
    localparam int K_PRE  = P + 1;
    localparam int K_REF1 = K_PRE + RP + 1;
    localparam int K_REF2 = K_REF1 + RFC + 1;
    localparam int K_LMR  = K_REF2 + RFC + 1;
    localparam int K_RDY  = K_LMR + MRD + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       mode_cfg = '0;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;
    logic              cmd_valid, init_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_init_seq #(
        .ADDR_W (ADDR_W), .BA_W (BA_W), .T_PWR (P), .T_RP (RP),
        .T_RFC (RFC), .T_MRD (MRD), .N_REF (2)
    ) u_sdram_init_seq (
        .clk (clk), .rst_n (rst_n), .mode_cfg (mode_cfg),
        .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
        .sd_we_n (sd_we_n), .sd_addr (sd_addr), .sd_ba (sd_ba),
        .cmd_valid (cmd_valid), .init_ready (init_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected cleaned mode word: bits 11,10,8,7 cleared; latency 2/3 kept, else 3.
    function automatic logic [11:0] exp_mode(input logic [11:0] raw);
        logic [11:0] w;
        w = raw & 12'h20F;
        w[6:4] = (raw[6:4] == 3'b010 || raw[6:4] == 3'b011) ? raw[6:4] : 3'b011;
        return w;
    endfunction

    // R1: hold reset for n cycles and check the inhibited bus.
    task automatic t_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111 && sd_addr == '0 &&
              sd_ba == '0 && !cmd_valid && !init_ready, "R1", "reset bus",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba, cmd_valid, init_ready},
              {4'b1111, 16'h0});
    endtask

    // R2..R10: release reset and check cycles 1..last against the schedule.
    task automatic t_sequence(input logic [11:0] cfg, input int last);
        logic [3:0]        ec;
        logic [ADDR_W-1:0] ea;
        string             tag;
        mode_cfg = cfg;
        rst_n    = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(posedge clk);
            @(negedge clk);
            ea = '0;
            if (k == K_PRE) begin
                ec = 4'b0010; ea[10] = 1'b1; tag = "R3";
            end else if (k == K_REF1) begin
                ec = 4'b0001; tag = "R4";
            end else if (k == K_REF2) begin
                ec = 4'b0001; tag = "R5";
            end else if (k == K_LMR) begin
                ec = 4'b0000; ea = exp_mode(cfg); tag = "R6/R7/R8";
            end else begin
                ec = 4'b0111;
                tag = (k <= P) ? "R2" : (k < K_REF1) ? "R4" : (k < K_LMR) ? "R5" : "R9";
            end
            check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == ec && sd_addr == ea && sd_ba == '0,
                  tag, $sformatf("cycle %0d cmd/addr/ba", k),
                  {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba},
                  {ec, ea, 2'b00});
            check(cmd_valid == (ec != 4'b0111), "R10", $sformatf("cycle %0d valid", k),
                  cmd_valid, (ec != 4'b0111));
            check(init_ready == (k >= K_RDY), "R9", $sformatf("cycle %0d ready", k),
                  init_ready, (k >= K_RDY));
        end
    endtask

    // R11: reset in mid-sequence, then a full clean restart.
    task automatic t_mid_reset(input logic [11:0] cfg);
        mode_cfg = cfg;
        rst_n    = 1'b1;
        for (int i = 0; i < K_REF1 + 2; i++) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111 && !init_ready, "R11",
              "mid reset inhibit", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        t_sequence(cfg, K_RDY + 3);
    endtask

    initial begin
        t_reset(3);
        t_sequence(12'h023, K_RDY + 8);      // CL=2 legal, nothing reserved set
        t_reset(2);
        t_sequence(12'hFFF, K_RDY + 2);      // all reserved set, CL=7 illegal
        t_reset(2);
        t_sequence(12'h5B2, K_RDY + 2);      // reserved set, CL=3 legal
        t_reset(2);
        t_sequence(12'h041, K_RDY + 2);      // CL=4 illegal
        t_reset(2);
        t_mid_reset(12'h230);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule